// File: doc/BRIEF.md
# Adaptive Critical Value Selector

This block lives in the leading core of a redundant core pair and decides, at the moment an instruction retires, whether its result is sent to the trailing core's result queue. It keeps a small record for every reorder-buffer slot. The record holds how many in-flight consumers have been renamed against the slot's value, and whether the slot was ever seen at the reorder-buffer head before it had executed.

Two tests can mark an instruction as critical. The first test is always active: an instruction with two or more in-flight consumers is critical. The second test marks an instruction that stalled unexecuted at the head. It is only active while a saturating counter is above a threshold. Retirement stalls caused by a full result queue push that counter up, and retirement stalls with any other cause pull it down.

The forward decision is made in the same cycle as retirement. The tag and value pass through unchanged.

Top module: `critValueSel`

## Requirements
- R1: After reset the stall counter is zero, so the head-stall test is inactive and `fwdValid` is low while `retireValid` is low.
- R2: A retiring instruction whose slot has recorded exactly `FANOUT_MIN` (default 2) consumers is forwarded in its retire cycle.
- R3: A retiring instruction with fewer than `FANOUT_MIN` consumers, and no active head-stall test, is not forwarded.
- R4: The per-slot consumer count saturates at `FANOUT_MIN`. Further consumer pulses keep the instruction critical.
- R5: The head-unexecuted mark is set in any cycle where `headValid` is high, `headExecuted` is low and `headIdx` names the slot. Once set, it stays set until the slot is reallocated, even after the instruction executes.
- R6: While the counter is at or below `STALL_THRESH`, a head-unexecuted mark alone does not cause a forward.
- R7: Each cycle with `stallQueueFull` high increments the counter. A cycle with only `stallOther` high decrements it. When both are high, the cycle counts as a queue-full stall. With neither high, the counter holds. The counter changes one cycle after the stall.
- R8: While the counter is strictly greater than `STALL_THRESH`, an instruction with a head-unexecuted mark is forwarded even with zero consumers. At a counter value equal to `STALL_THRESH` it is not forwarded.
- R9: The counter saturates at 2^`CTR_W`-1 and at zero.
- R10: `fwdValid` is high only with `retireValid`. When `fwdValid` is high, `fwdTag` and `fwdValue` equal `retireTag` and `retireValue`.
- R11: `allocValid` clears both the consumer count and the head-unexecuted mark of slot `allocIdx`. Allocation takes priority over a same-cycle consumer pulse or head observation on that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | A new instruction enters slot `allocIdx` |
| allocIdx | input | $clog2(ROB_DEPTH) | Slot being allocated |
| consumeValid | input | 1 | A renamed instruction reads the value of slot `consumeIdx` |
| consumeIdx | input | $clog2(ROB_DEPTH) | Producer slot of the new consumer |
| headValid | input | 1 | The reorder-buffer head holds an instruction |
| headIdx | input | $clog2(ROB_DEPTH) | Slot at the head |
| headExecuted | input | 1 | The head instruction has finished executing |
| stallQueueFull | input | 1 | Retirement is stalled by a full result queue this cycle |
| stallOther | input | 1 | Retirement is stalled for any other reason this cycle |
| retireValid | input | 1 | An instruction retires this cycle |
| retireIdx | input | $clog2(ROB_DEPTH) | Slot of the retiring instruction |
| retireTag | input | TAG_W | Tag of the retiring instruction |
| retireValue | input | DATA_W | Result of the retiring instruction |
| fwdValid | output | 1 | Forward this result to the trailing core |
| fwdTag | output | TAG_W | Tag of the forwarded result |
| fwdValue | output | DATA_W | Forwarded result |

## Verification
The bench builds the block with an 8-slot buffer, a 3-bit counter and a threshold of 3, and leaves `FANOUT_MIN` at 2. With these values, both saturation ends and the exact threshold crossing can be reached in a handful of stall pulses. The saturation value 7 and the threshold 3 are far enough apart that a counter which failed to saturate, or which decremented on a combined stall, is seen as a wrong mode switch when a head-stalled instruction is probed. The narrow-mode cases run from a vector table over consumer counts of zero to five. Reallocation, persistence of the head mark and the mode switch are directed tests.

// File: rtl/critSelPkg.sv
package critSelPkg;

  // Strobes sent from the stall control to the selection datapath
  typedef struct packed {
    logic wideMode;   // head-stall test enabled
    logic ctrMoved;   // counter changed on the last edge
  } critCtl_t;

endpackage

// File: rtl/critStallCtl.sv
module critStallCtl
  import critSelPkg::*;
#(
  parameter int CTR_W        = 4,
  parameter int STALL_THRESH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stallQueueFull,
  input  logic             stallOther,
  output critCtl_t         ctl,
  output logic [CTR_W-1:0] stallCtr
);

  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_THR  = CTR_W'(STALL_THRESH);

  logic             upReq;
  logic             downReq;
  logic [CTR_W-1:0] ctrNext;
  logic             movedQ;

  // Queue-full wins when both causes are flagged in one cycle
  assign upReq   = stallQueueFull && (stallCtr != CTR_MAX);
  assign downReq = !stallQueueFull && stallOther && (stallCtr != '0);

  always_comb begin
    ctrNext = stallCtr;
    if (upReq)        ctrNext = stallCtr + 1'b1;
    else if (downReq) ctrNext = stallCtr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCtr <= '0;
      movedQ   <= 1'b0;
    end else begin
      stallCtr <= ctrNext;
      movedQ   <= upReq || downReq;
    end
  end

  assign ctl.wideMode = stallCtr > CTR_THR;
  assign ctl.ctrMoved = movedQ;

endmodule

// File: rtl/critSlotTrack.sv
module critSlotTrack
  import critSelPkg::*;
#(
  parameter int ROB_DEPTH  = 16,
  parameter int TAG_W      = 8,
  parameter int DATA_W     = 64,
  parameter int FANOUT_MIN = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  critCtl_t                     ctl,
  input  logic                         allocValid,
  input  logic [$clog2(ROB_DEPTH)-1:0] allocIdx,
  input  logic                         consumeValid,
  input  logic [$clog2(ROB_DEPTH)-1:0] consumeIdx,
  input  logic                         headValid,
  input  logic [$clog2(ROB_DEPTH)-1:0] headIdx,
  input  logic                         headExecuted,
  input  logic                         retireValid,
  input  logic [$clog2(ROB_DEPTH)-1:0] retireIdx,
  input  logic [TAG_W-1:0]             retireTag,
  input  logic [DATA_W-1:0]            retireValue,
  output logic                         fwdValid,
  output logic [TAG_W-1:0]             fwdTag,
  output logic [DATA_W-1:0]            fwdValue
);

  localparam int IDX_W = $clog2(ROB_DEPTH);
  localparam int CW    = $clog2(FANOUT_MIN + 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(FANOUT_MIN);

  logic [ROB_DEPTH-1:0][CW-1:0] consCnt;
  logic [ROB_DEPTH-1:0][CW-1:0] consCntNext;
  logic [ROB_DEPTH-1:0]         headSeen;
  logic [ROB_DEPTH-1:0]         headSeenNext;

  // Per-slot next-state: allocation clears, consumers saturate, head mark sticks
  for (genvar g = 0; g < ROB_DEPTH; g++) begin : gSlot
    logic allocHit;
    logic consHit;
    logic headHit;
    assign allocHit = allocValid && (allocIdx == IDX_W'(g));
    assign consHit  = consumeValid && (consumeIdx == IDX_W'(g));
    assign headHit  = headValid && !headExecuted && (headIdx == IDX_W'(g));

    assign consCntNext[g] = allocHit ? '0 :
                            (consHit && consCnt[g] != CNT_SAT) ? consCnt[g] + 1'b1 :
                            consCnt[g];
    assign headSeenNext[g] = allocHit ? 1'b0 : (headSeen[g] || headHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      consCnt  <= '0;
      headSeen <= '0;
    end else begin
      consCnt  <= consCntNext;
      headSeen <= headSeenNext;
    end
  end

  logic [CW-1:0] selCnt;
  logic          selSeen;
  logic          byFanout;
  logic          byHead;

  assign selCnt   = consCnt[retireIdx];
  assign selSeen  = headSeen[retireIdx];
  assign byFanout = (selCnt == CNT_SAT);
  assign byHead   = ctl.wideMode && selSeen;

  assign fwdValid = retireValid && (byFanout || byHead);
  assign fwdTag   = retireTag;
  assign fwdValue = retireValue;

endmodule

// File: rtl/critValueSel.sv
module critValueSel
  import critSelPkg::*;
#(
  parameter int ROB_DEPTH    = 16,
  parameter int TAG_W        = 8,
  parameter int DATA_W       = 64,
  parameter int FANOUT_MIN   = 2,
  parameter int CTR_W        = 4,
  parameter int STALL_THRESH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         allocValid,
  input  logic [$clog2(ROB_DEPTH)-1:0] allocIdx,
  input  logic                         consumeValid,
  input  logic [$clog2(ROB_DEPTH)-1:0] consumeIdx,
  input  logic                         headValid,
  input  logic [$clog2(ROB_DEPTH)-1:0] headIdx,
  input  logic                         headExecuted,
  input  logic                         stallQueueFull,
  input  logic                         stallOther,
  input  logic                         retireValid,
  input  logic [$clog2(ROB_DEPTH)-1:0] retireIdx,
  input  logic [TAG_W-1:0]             retireTag,
  input  logic [DATA_W-1:0]            retireValue,
  output logic                         fwdValid,
  output logic [TAG_W-1:0]             fwdTag,
  output logic [DATA_W-1:0]            fwdValue
);

  critCtl_t         ctl;
  logic [CTR_W-1:0] stallCtr;

  critStallCtl #(
    .CTR_W        (CTR_W),
    .STALL_THRESH (STALL_THRESH)
  ) i_ctl (
    .clk            (clk),
    .rstN           (rstN),
    .stallQueueFull (stallQueueFull),
    .stallOther     (stallOther),
    .ctl            (ctl),
    .stallCtr       (stallCtr)
  );

  critSlotTrack #(
    .ROB_DEPTH  (ROB_DEPTH),
    .TAG_W      (TAG_W),
    .DATA_W     (DATA_W),
    .FANOUT_MIN (FANOUT_MIN)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .allocValid   (allocValid),
    .allocIdx     (allocIdx),
    .consumeValid (consumeValid),
    .consumeIdx   (consumeIdx),
    .headValid    (headValid),
    .headIdx      (headIdx),
    .headExecuted (headExecuted),
    .retireValid  (retireValid),
    .retireIdx    (retireIdx),
    .retireTag    (retireTag),
    .retireValue  (retireValue),
    .fwdValid     (fwdValid),
    .fwdTag       (fwdTag),
    .fwdValue     (fwdValue)
  );

endmodule

// File: rtl/critValueSelChk.sv
module critValueSelChk #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 64,
  parameter int CTR_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              stallQueueFull,
  input logic              stallOther,
  input logic [CTR_W-1:0]  stallCtr,
  input logic              retireValid,
  input logic [TAG_W-1:0]  retireTag,
  input logic [DATA_W-1:0] retireValue,
  input logic              fwdValid,
  input logic [TAG_W-1:0]  fwdTag,
  input logic [DATA_W-1:0] fwdValue
);

  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

  p_fwd_only_on_retire_r10: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> retireValid);

  p_passthrough_r10: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (fwdTag == retireTag && fwdValue == retireValue));

  p_inc_on_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stallQueueFull && stallCtr != CMAX) |=> stallCtr == CTR_W'($past(stallCtr) + 1'b1));

  p_dec_on_other_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!stallQueueFull && stallOther && stallCtr != '0) |=> stallCtr == CTR_W'($past(stallCtr) - 1'b1));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!stallQueueFull && !stallOther) |=> $stable(stallCtr));

  p_sat_top_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stallQueueFull && stallCtr == CMAX) |=> stallCtr == CMAX);

  p_sat_bottom_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stallQueueFull && stallCtr == '0) |=> stallCtr == '0);

endmodule

bind critValueSel critValueSelChk #(
  .TAG_W  (TAG_W),
  .DATA_W (DATA_W),
  .CTR_W  (CTR_W)
) i_chk (
  .clk            (clk),
  .rstN           (rstN),
  .stallQueueFull (stallQueueFull),
  .stallOther     (stallOther),
  .stallCtr       (stallCtr),
  .retireValid    (retireValid),
  .retireTag      (retireTag),
  .retireValue    (retireValue),
  .fwdValid       (fwdValid),
  .fwdTag         (fwdTag),
  .fwdValue       (fwdValue)
);

// File: tb/test_critValueSel.sv
module test_critValueSel;

  localparam int ROB_DEPTH = 8;
  localparam int TAG_W     = 8;
  localparam int DATA_W    = 32;
  localparam int IDX_W     = $clog2(ROB_DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0, consumeValid = 1'b0, headValid = 1'b0, headExecuted = 1'b0;
  logic stallQueueFull = 1'b0, stallOther = 1'b0, retireValid = 1'b0;
  logic [IDX_W-1:0]  allocIdx = '0, consumeIdx = '0, headIdx = '0, retireIdx = '0;
  logic [TAG_W-1:0]  retireTag = '0;
  logic [DATA_W-1:0] retireValue = '0;
  logic              fwdValid;
  logic [TAG_W-1:0]  fwdTag;
  logic [DATA_W-1:0] fwdValue;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  critValueSel #(
    .ROB_DEPTH(ROB_DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .FANOUT_MIN(2), .CTR_W(3), .STALL_THRESH(3)
  ) i_critValueSel (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocIdx(allocIdx),
    .consumeValid(consumeValid), .consumeIdx(consumeIdx),
    .headValid(headValid), .headIdx(headIdx), .headExecuted(headExecuted),
    .stallQueueFull(stallQueueFull), .stallOther(stallOther),
    .retireValid(retireValid), .retireIdx(retireIdx),
    .retireTag(retireTag), .retireValue(retireValue),
    .fwdValid(fwdValid), .fwdTag(fwdTag), .fwdValue(fwdValue)
  );

  // Narrow-mode vectors: [4] expected forward, [3] head stall, [2:0] consumer pulses
  localparam int NVEC = 8;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b000_0_0_000, 8'b000_0_0_001, 8'b000_1_0_010, 8'b000_1_0_011,
    8'b000_1_0_101, 8'b000_0_1_000, 8'b000_0_1_001, 8'b000_1_1_010
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Allocate (optional), add consumers, observe head state, wait, then retire and check
  task automatic runInstr(input int idx, input int nCons, input bit headStall, input int gap,
                          input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] val,
                          input bit expFwd, input string req, input bit doAlloc);
    if (doAlloc) begin
      @(negedge clk); allocValid = 1'b1; allocIdx = IDX_W'(idx);
      @(negedge clk); allocValid = 1'b0;
    end
    for (int k = 0; k < nCons; k++) begin
      @(negedge clk); consumeValid = 1'b1; consumeIdx = IDX_W'(idx);
    end
    @(negedge clk); consumeValid = 1'b0;
    if (headStall) begin
      headValid = 1'b1; headIdx = IDX_W'(idx); headExecuted = 1'b0;
      @(negedge clk); headExecuted = 1'b1;
    end
    for (int k = 0; k < gap; k++) @(negedge clk);
    headValid = 1'b0; headExecuted = 1'b0;
    retireValid = 1'b1; retireIdx = IDX_W'(idx); retireTag = tag; retireValue = val;
    #1;
    check(req, 64'(fwdValid), 64'(expFwd));
    if (expFwd) begin
      check({req, " tag"}, 64'(fwdTag), 64'(tag));
      check({req, " value"}, 64'(fwdValue), 64'(val));
    end
    @(negedge clk); retireValid = 1'b0;
  endtask

  task automatic stall(input bit qf, input bit oth, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); stallQueueFull = qf; stallOther = oth;
    end
    @(negedge clk); stallQueueFull = 1'b0; stallOther = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 idle no forward", 64'(fwdValid), 64'd0);
    runInstr(0, 0, 1'b1, 0, 8'h01, 32'h1, 1'b0, "R1 head stall off after reset", 1'b1);

    // Table walk, narrow mode
    for (int i = 0; i < NVEC; i++) begin
      int n; bit hs; bit ex; string rq;
      n  = int'(VEC[i][2:0]);
      hs = VEC[i][3];
      ex = VEC[i][4];
      if (hs && n < 2)  rq = "R6";
      else if (n >= 3)  rq = "R4";
      else if (n == 2)  rq = "R2";
      else              rq = "R3";
      runInstr(i, n, hs, 1, TAG_W'(8'h10 + i), DATA_W'(32'hA000 + i), ex, rq, 1'b1);
    end

    // R11: reallocation clears consumer count
    @(negedge clk); allocValid = 1'b1; allocIdx = 3'd5;
    @(negedge clk); allocValid = 1'b0; consumeValid = 1'b1; consumeIdx = 3'd5;
    @(negedge clk); consumeValid = 1'b1;
    @(negedge clk); consumeValid = 1'b0;
    runInstr(5, 0, 1'b0, 0, 8'h55, 32'h55, 1'b0, "R11 realloc clears count", 1'b1);
    // R11: allocation beats a same-cycle consumer pulse
    runInstr(6, 2, 1'b0, 0, 8'h60, 32'h60, 1'b1, "R2 pre", 1'b1);
    @(negedge clk); allocValid = 1'b1; allocIdx = 3'd6; consumeValid = 1'b1; consumeIdx = 3'd6;
    @(negedge clk); allocValid = 1'b0; consumeValid = 1'b0;
    runInstr(6, 1, 1'b0, 0, 8'h61, 32'h61, 1'b0, "R11 alloc priority", 1'b0);

    // R8: threshold crossing
    stall(1'b1, 1'b0, 3);
    runInstr(1, 0, 1'b1, 0, 8'h21, 32'h21, 1'b0, "R8 at threshold", 1'b1);
    stall(1'b1, 1'b0, 1);
    runInstr(1, 0, 1'b1, 0, 8'h22, 32'h22, 1'b1, "R8 above threshold", 1'b1);
    runInstr(2, 0, 1'b0, 0, 8'h23, 32'h23, 1'b0, "R3 wide no mark", 1'b1);
    runInstr(2, 2, 1'b0, 0, 8'h24, 32'h24, 1'b1, "R2 wide fanout", 1'b1);
    // R5: mark persists after execution over many cycles
    runInstr(3, 0, 1'b1, 6, 8'h25, 32'h25, 1'b1, "R5 sticky mark", 1'b1);
    // R11: realloc clears head mark
    runInstr(3, 0, 1'b0, 0, 8'h26, 32'h26, 1'b0, "R11 realloc clears mark", 1'b1);

    // R7: both flags count as queue-full (4 -> 5), one other -> 4 still wide
    stall(1'b1, 1'b1, 1);
    stall(1'b0, 1'b1, 1);
    runInstr(4, 0, 1'b1, 0, 8'h31, 32'h31, 1'b1, "R7 both flags increment", 1'b1);
    stall(1'b0, 1'b1, 1);
    runInstr(4, 0, 1'b1, 0, 8'h32, 32'h32, 1'b0, "R7 other decrements", 1'b1);

    // R9: top saturation, 7 then 3 decs -> 4 wide, 4th -> 3 narrow
    stall(1'b1, 1'b0, 10);
    stall(1'b0, 1'b1, 3);
    runInstr(0, 0, 1'b1, 0, 8'h41, 32'h41, 1'b1, "R9 top saturation wide", 1'b1);
    stall(1'b0, 1'b1, 1);
    runInstr(0, 0, 1'b1, 0, 8'h42, 32'h42, 1'b0, "R9 top saturation narrow", 1'b1);

    // R9: bottom saturation, 0 then 3 incs narrow, 4th wide
    stall(1'b0, 1'b1, 10);
    stall(1'b1, 1'b0, 3);
    runInstr(7, 0, 1'b1, 0, 8'h51, 32'h51, 1'b0, "R9 bottom saturation narrow", 1'b1);
    stall(1'b1, 1'b0, 1);
    runInstr(7, 0, 1'b1, 0, 8'h52, 32'h52, 1'b1, "R9 bottom saturation wide", 1'b1);

    // R10: no retire, no forward even for a critical slot
    runInstr(1, 3, 1'b0, 0, 8'h71, 32'h71, 1'b1, "R4 wide fanout", 1'b1);
    @(negedge clk); #1;
    check("R10 no retire no forward", 64'(fwdValid), 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule